// File: doc/BRIEF.md
# I2S Stereo to Balanced Mono Splitter

This block takes one I2S stereo stream and turns it into two I2S data lines that share one regenerated word select. Each channel slot is 32 bit clocks long, so a full word-select period is 64 bit clocks. The sample sits in the leading 16 bits of its slot, MSB first, and the MSB arrives one bit clock after the word-select edge. Each output line drives one mono DAC used differentially. The left line carries the left sample in the word-select-low slot and its two's-complement negation in the word-select-high slot. The right line does the same with the right sample.

The input is sampled on the rising bit-clock edge. Each slot is gathered into a word, and one complete stereo frame is held while it is replayed. The replayed frame is first sent as true values and then as negated values. Every output is registered on the falling bit-clock edge, which gives the select logic half a bit period to settle. A mute input zeroes both lines. A phase-invert input swaps which slot carries the true sample and which carries the negated one. After reset both lines stay silent until two complete input frames have been received.

Top module: `bal_split`

## Requirements
- R1: While reset is asserted and directly after it, ws_o, sdl_o and sdr_o are 0.
- R2: An input slot is the 32 bits sampled on rising edges after a word-select change, MSB first. ws_i low marks left and high marks right. Only the top 16 bits form the sample, and the lower 16 bits have no effect on either output.
- R3: ws_o follows ws_i half a bit clock later and so toggles every 32 bit clocks. Each output word starts with its MSB one bit clock after the ws_o edge. All outputs change on the falling bit-clock edge.
- R4: With inv_i low, sdl_o carries {left sample, 16 zero bits} in the ws_o-low slot and {negated left sample, 16 zero bits} in the ws_o-high slot.
- R5: With inv_i low, sdr_o carries the right sample in the same way: true in the low slot, negated in the high slot, low 16 bits zero.
- R6: Negation is two's complement (invert all bits, add one). A sample of 0 negates to 0 and 0xFFFF negates to 0x0001.
- R7: Negating the most negative sample 0x8000 gives 0x7FFF.
- R8: A ws_o falling edge occurs on the falling bit-clock edge right after the rising edge that samples the input's falling word select. The output frame that starts there carries the input frame whose last right bit was sampled at that rising edge.
- R9: mute_i is sampled on each falling edge. When it is high, the bits driven on sdl_o and sdr_o at that edge are 0.
- R10: inv_i is sampled at each output slot start. When it is high, the ws_o-low slot carries the negated sample and the ws_o-high slot carries the true sample, on both lines.
- R11: Both data lines stay 0 until the output frame built from the second completed input frame. That frame and every later one is sent normally.
- R12: Output values depend only on the held frame and on mute_i and inv_i. Back-to-back frames with unrelated values are each sent unchanged in content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; input sampled on rising edge, outputs driven on falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Input word select, low for left |
| sd_i | input | 1 | Input serial data |
| mute_i | input | 1 | Forces both output data lines to zero |
| inv_i | input | 1 | Swaps true and negated slots |
| ws_o | output | 1 | Shared output word select |
| sdl_o | output | 1 | Balanced left-channel serial data |
| sdr_o | output | 1 | Balanced right-channel serial data |

## Verification
The bench feeds 0x8000, 0x7FFF, 0, 0xFFFF and 0x0001 directly. A design that only inverted the bits, or that let the most negative value wrap, would send the wrong negated word. Random garbage in the unused low 16 bits of each input slot exposes a design that lets those bits reach the output. The bench also decodes both output lines as an I2S receiver and matches each output frame to the input frame the timing rule names. An off-by-one-slot alignment, a swapped true/negated slot, or a startup that plays stale frames would therefore show up as wrong words or a wrong slot length. Mute and invert are changed between frames, so a design that ignored them, or applied them to the wrong slot, would produce words that differ from the expected ones.

// File: rtl/bal_split.sv
`timescale 1ns/1ps
module bal_split #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_i,
  input  logic sd_i,
  input  logic mute_i,
  input  logic inv_i,
  output logic ws_o,
  output logic sdl_o,
  output logic sdr_o
);
  localparam int PAD = SLOT_W - SAMPLE_W;
  localparam int CW  = $clog2(SLOT_W);
  localparam logic [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] S_MAX = ~S_MIN;

  logic                ws_q;
  logic [SLOT_W-2:0]   sh;
  logic [SAMPLE_W-1:0] lw, fl, fr;
  logic [1:0]          nfr;

  wire slot_end = ws_i ^ ws_q;
  wire [SAMPLE_W-1:0] samp = sh[SLOT_W-2 -: SAMPLE_W];
  wire armed = (nfr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b0;
      sh   <= '0;
      lw   <= '0;
      fl   <= '0;
      fr   <= '0;
      nfr  <= '0;
    end else begin
      ws_q <= ws_i;
      sh   <= {sh[SLOT_W-3:0], sd_i};
      if (slot_end) begin
        if (!ws_q) lw <= samp;
        else begin
          fl <= lw;
          fr <= samp;
          if (!armed) nfr <= nfr + 2'd1;
        end
      end
    end
  end

  function automatic logic [SAMPLE_W-1:0] neg_sat(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] r;
    r = ~s + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    return (s == S_MIN) ? S_MAX : r;
  endfunction

  wire [SAMPLE_W-1:0] nl = neg_sat(fl);
  wire [SAMPLE_W-1:0] nr = neg_sat(fr);

  wire oload    = ws_q ^ ws_o;
  wire pick_neg = ws_q ^ inv_i;
  wire [SLOT_W-1:0] wl = {(pick_neg ? nl : fl), {PAD{1'b0}}};
  wire [SLOT_W-1:0] wr = {(pick_neg ? nr : fr), {PAD{1'b0}}};

  logic [SLOT_W-1:0] olsh, orsh;
  logic              live;
  logic [CW-1:0]     ocnt;
  logic [1:0]        ntog;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_o  <= 1'b0;
      sdl_o <= 1'b0;
      sdr_o <= 1'b0;
      olsh  <= '0;
      orsh  <= '0;
      live  <= 1'b0;
      ocnt  <= '0;
      ntog  <= '0;
    end else begin
      ws_o  <= ws_q;
      sdl_o <= live & ~mute_i & olsh[SLOT_W-1];
      sdr_o <= live & ~mute_i & orsh[SLOT_W-1];
      if (oload) begin
        olsh <= wl;
        orsh <= wr;
        ocnt <= '0;
        if (ntog != 2'd2) ntog <= ntog + 2'd1;
        if (!ws_q) live <= armed;
      end else begin
        olsh <= {olsh[SLOT_W-2:0], 1'b0};
        orsh <= {orsh[SLOT_W-2:0], 1'b0};
        ocnt <= ocnt + 1'b1;
      end
    end
  end

  // R3
  slot_len_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (oload && ntog == 2'd2) |-> (ocnt == CW'(SLOT_W-1)));

  // R9
  mute_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $past(mute_i) |-> (!sdl_o && !sdr_o));

  // R11
  startup_quiet_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(live) |-> (!sdl_o && !sdr_o));

  // R6
  always_comb begin
    if (rst_n) begin
      neg_sum_chk: assert (fl == S_MIN || SAMPLE_W'(nl + fl) == '0);
    end
  end
endmodule

// File: tb/sim_bal_split.sv
`timescale 1ns/1ps
module sim_bal_split;
  localparam int NF = 180;

  logic clk = 0, rst_n = 0, ws_i = 0, sd_i = 0, mute_i = 0, inv_i = 0;
  logic ws_o, sdl_o, sdr_o;
  always #2 clk = ~clk;

  bal_split u0 (.clk(clk), .rst_n(rst_n), .ws_i(ws_i), .sd_i(sd_i),
                .mute_i(mute_i), .inv_i(inv_i),
                .ws_o(ws_o), .sdl_o(sdl_o), .sdr_o(sdr_o));

  int tests = 0, fails = 0;
  logic [15:0] fL[NF], fR[NF], gL[NF], gR[NF];
  bit fm[NF], fv[NF];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nsat(input logic [15:0] s);
    if (s == 16'h8000) return 16'h7FFF;
    return ~s + 16'd1;
  endfunction

  function automatic logic [31:0] expw(input logic [15:0] s, input bit neg);
    return neg ? {nsat(s), 16'h0000} : {s, 16'h0000};
  endfunction

  function automatic string tag(input logic [15:0] s, input bit inv, input string base);
    if (inv) return "R10 R6 R8";
    if (s == 16'h8000) return "R7 R2 R8";
    if (s == 16'h0000 || s == 16'hFFFF) return "R6 R2 R8";
    return {base, " R2 R12 R8"};
  endfunction

  logic [31:0] rl, rr, lowL, lowR;
  logic rws = 0;
  int rcnt = 0, ntr = 0, ofc = 0;

  always @(posedge clk) begin
    if (rst_n && !done) begin
      rl = {rl[30:0], sdl_o};
      rr = {rr[30:0], sdr_o};
      rcnt++;
      if (ws_o != rws) begin
        ntr++;
        if (ntr > 2) chk(rcnt == 32, "R3 slot length", rcnt, 32);
        rcnt = 0;
        if (!rws) begin
          lowL = rl; lowR = rr;
        end else begin
          int idx;
          idx = ofc - 1;
          if (idx < 1) begin
            chk(lowL == 0 && rl == 0, "R11 left quiet", {lowL[15:0], rl[15:0]}, 0);
            chk(lowR == 0 && rr == 0, "R11 right quiet", {lowR[15:0], rr[15:0]}, 0);
          end else if (idx < NF) begin
            if (fm[idx]) begin
              chk(lowL == 0 && rl == 0, "R9 mute left", lowL | rl, 0);
              chk(lowR == 0 && rr == 0, "R9 mute right", lowR | rr, 0);
            end else begin
              chk(lowL == expw(fL[idx], fv[idx]), tag(fL[idx], fv[idx], "R4"), lowL, expw(fL[idx], fv[idx]));
              chk(rl == expw(fL[idx], !fv[idx]), tag(fL[idx], fv[idx], "R4"), rl, expw(fL[idx], !fv[idx]));
              chk(lowR == expw(fR[idx], fv[idx]), tag(fR[idx], fv[idx], "R5"), lowR, expw(fR[idx], fv[idx]));
              chk(rr == expw(fR[idx], !fv[idx]), tag(fR[idx], fv[idx], "R5"), rr, expw(fR[idx], !fv[idx]));
            end
          end
          ofc++;
        end
      end
      rws = ws_o;
    end
  end

  initial begin
    logic [31:0] w;
    bit prev;
    void'($urandom(32'd4242));
    for (int g = 0; g < NF; g++) begin
      fL[g] = 16'($urandom); fR[g] = 16'($urandom);
      gL[g] = 16'($urandom); gR[g] = 16'($urandom);
      fm[g] = ($urandom % 10) == 0;
      fv[g] = ($urandom % 4) == 0;
    end
    for (int g = 0; g < 10; g++) begin fm[g] = 0; fv[g] = 0; end
    fL[2] = 16'h8000; fR[2] = 16'h7FFF;
    fL[3] = 16'h0000; fR[3] = 16'hFFFF;
    fL[4] = 16'h0001; fR[4] = 16'h8001;
    fL[5] = 16'h8000; fR[5] = 16'h1234; fv[5] = 1;
    fm[6] = 1;
    fm[7] = 1; fv[7] = 1;
    fL[8] = 16'h7FFF; fR[8] = 16'h0000;
    fL[9] = 16'hFFFF; fR[9] = 16'h8000; fv[9] = 1;

    repeat (4) @(posedge clk);
    #1;
    chk(ws_o == 0 && sdl_o == 0 && sdr_o == 0, "R1 reset outputs", {ws_o, sdl_o, sdr_o}, 0);
    @(negedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    chk(ws_o == 0 && sdl_o == 0 && sdr_o == 0, "R1 after reset", {ws_o, sdl_o, sdr_o}, 0);

    prev = 0;
    for (int g = 0; g < NF; g++) begin
      for (int k = 0; k < 64; k++) begin
        @(negedge clk); #1;
        if (k == 0) begin
          mute_i = (g > 0) ? fm[g-1] : 1'b0;
          inv_i  = (g > 0) ? fv[g-1] : 1'b0;
        end
        ws_i = (k >= 32);
        sd_i = prev;
        w = (k < 32) ? {fL[g], gL[g]} : {fR[g], gR[g]};
        prev = w[31 - (k % 32)];
      end
    end
    repeat (70) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule